// File: doc/BRIEF.md
# Key-Locked System Configuration Registers

This block holds a small set of 16-bit control registers on a simple synchronous register bus. The bus has a word address, a write strobe, write data and combinational read data. One register is a lock key. While it does not hold the unlock value, the protected configuration fields ignore writes. The key register itself can always be written and read back.

The protected fields drive two live functions. A flash read wait-state generator accepts a one-cycle read request and answers with a single-cycle ready pulse a programmed number of cycles later, passing the array data only in that cycle. A RAM window checker compares each RAM access offset against the selected RAM size. It raises a one-cycle out-of-range flag and returns zero data for offsets past the end.

Top module: `syscfg_lock`

## Requirements
- R1: After reset the key register reads 0x0000, the RAM size field reads 2 and the flash wait field reads 1; the configuration fields are locked.
- R2: Writing 0x0096 to the key register (word address 0) unlocks the fields. Writing any other value locks them. The key register always stores and returns the last value written.
- R3: While locked, writes to the RAM size field (word 1, bits 2:0) and the flash wait field (word 2, bits 1:0) leave them unchanged.
- R4: A write of a RAM size code from 3 to 7 is ignored even when unlocked. Codes 0, 1 and 2 select 512, 1024 and 2048 bytes.
- R5: Reads of words 1 and 2 return 0 in bit 8 and in every bit above the field, whatever was written.
- R6: A flash request accepted while idle produces `fl_ready` high for exactly one cycle, (wait field + 1) cycles after the request cycle. `fl_rdata` equals `fl_arr_data` in that cycle and is zero otherwise.
- R7: Changing the flash wait field during an access does not change the length of that access. The new value applies from the next request.
- R8: A RAM access whose offset is at or above the selected size sets `ram_oor` high in the following cycle only, with `ram_rdata` zero.
- R9: A RAM access inside the window returns `ram_arr_data` on `ram_rdata` in the following cycle with `ram_oor` low.
- R10: A flash request that arrives while an access is in progress, including in its ready cycle, is ignored.
- R11: Word address 3 reads as zero and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register word address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| fl_req | input | 1 | Flash read request, one cycle |
| fl_arr_data | input | 16 | Data from the flash array |
| fl_ready | output | 1 | Flash read complete |
| fl_rdata | output | 16 | Flash read data, valid with ready |
| ram_req | input | 1 | RAM access strobe |
| ram_addr | input | 11 | RAM byte offset |
| ram_arr_data | input | 16 | Data from the RAM array |
| ram_oor | output | 1 | Access was beyond the RAM window |
| ram_rdata | output | 16 | RAM read data, zero when out of range |

## Verification
On every cycle, the embedded assertions check several invariants. Locked fields stay stable, the RAM size code never holds a reserved value, ready never lasts two cycles, and data outside a ready or in-window cycle is zero. Some behaviours appear only in the bench scenarios. These are the exact ready latency for each wait code, the latching of the wait value at request time, and the ignoring of requests during a busy access. The bench scenarios also cover the key values that unlock or lock and the window edges at 511, 1023 and 2047 against 512, 1024 and 2048.

// File: rtl/syscfg_pkg.sv
package syscfg_pkg;
  localparam int REG_W = 16;
  typedef enum logic [1:0] {
    SEL_KEY    = 2'd0,
    SEL_RAMSZ  = 2'd1,
    SEL_FLWAIT = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;
  localparam int RAMSZ_W   = 3;
  localparam int FLWAIT_W  = 2;
  localparam logic [RAMSZ_W-1:0]  RAMSZ_RST  = 3'd2;
  localparam logic [RAMSZ_W-1:0]  RAMSZ_MAX  = 3'd2;
  localparam logic [FLWAIT_W-1:0] FLWAIT_RST = 2'd1;
endpackage

// File: rtl/syscfg_regbank.sv
module syscfg_regbank
  import syscfg_pkg::*;
#(
  parameter logic [REG_W-1:0] KEY_VAL = 16'h0096
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [1:0]          addr,
  input  logic [REG_W-1:0]    wdata,
  output logic [REG_W-1:0]    rdata,
  output logic [RAMSZ_W-1:0]  ramsz_o,
  output logic [FLWAIT_W-1:0] flwait_o
);
  logic [REG_W-1:0]    key_q, key_d;
  logic [RAMSZ_W-1:0]  ramsz_q, ramsz_d;
  logic [FLWAIT_W-1:0] flw_q, flw_d;
  logic                unlocked;

  assign unlocked = (key_q == KEY_VAL);

  always_comb begin
    key_d   = key_q;
    ramsz_d = ramsz_q;
    flw_d   = flw_q;
    if (we) begin
      case (reg_sel_e'(addr))
        SEL_KEY:    key_d = wdata;
        SEL_RAMSZ:  if (unlocked && (wdata[RAMSZ_W-1:0] <= RAMSZ_MAX)) ramsz_d = wdata[RAMSZ_W-1:0];
        SEL_FLWAIT: if (unlocked) flw_d = wdata[FLWAIT_W-1:0];
        default:    ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (reg_sel_e'(addr))
      SEL_KEY:    rdata = key_q;
      SEL_RAMSZ:  rdata[RAMSZ_W-1:0]  = ramsz_q;
      SEL_FLWAIT: rdata[FLWAIT_W-1:0] = flw_q;
      default:    rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q   <= '0;
      ramsz_q <= RAMSZ_RST;
      flw_q   <= FLWAIT_RST;
    end else begin
      key_q   <= key_d;
      ramsz_q <= ramsz_d;
      flw_q   <= flw_d;
    end
  end

  assign ramsz_o  = ramsz_q;
  assign flwait_o = flw_q;

  // R3: a locked bank keeps its protected fields
  p_locked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> ($stable(ramsz_q) && $stable(flw_q)));
  // R4: reserved size codes never land in the field
  p_legal_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ramsz_q <= RAMSZ_MAX);
endmodule

// File: rtl/syscfg_flash_wait.sv
module syscfg_flash_wait #(
  parameter int WAIT_W = 2,
  parameter int DW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WAIT_W-1:0] wait_cfg,
  input  logic              req,
  input  logic [DW-1:0]     arr_data,
  output logic              ready,
  output logic [DW-1:0]     rdata
);
  logic              busy_q, busy_d;
  logic [WAIT_W-1:0] remain_q, remain_d;

  always_comb begin
    busy_d   = busy_q;
    remain_d = remain_q;
    if (!busy_q) begin
      if (req) begin
        busy_d   = 1'b1;
        remain_d = wait_cfg;
      end
    end else if (remain_q == '0) begin
      busy_d = 1'b0;
    end else begin
      remain_d = remain_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      remain_q <= '0;
    end else begin
      busy_q   <= busy_d;
      remain_q <= remain_d;
    end
  end

  assign ready = busy_q && (remain_q == '0);
  assign rdata = ready ? arr_data : '0;

  // R6: ready is a single-cycle pulse
  p_ready_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);
  // R6: no data leaks outside the ready cycle
  p_rdata_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (rdata == '0));
  // R10: an access never restarts while one is running
  p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && remain_q != '0) |=> busy_q);
endmodule

// File: rtl/syscfg_ram_window.sv
module syscfg_ram_window #(
  parameter int AW         = 11,
  parameter int DW         = 16,
  parameter int CODE_W     = 3,
  parameter int BASE_SHIFT = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] size_code,
  input  logic              req,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     arr_data,
  output logic              oor,
  output logic [DW-1:0]     rdata
);
  localparam int LW = AW + 1;
  logic [LW-1:0] limit;
  logic          over;
  logic          oor_q, oor_d;
  logic [DW-1:0] rd_q, rd_d;

  assign limit = LW'(1) << (BASE_SHIFT + int'(size_code));
  assign over  = ({1'b0, addr} >= limit);

  always_comb begin
    oor_d = req && over;
    rd_d  = (req && !over) ? arr_data : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oor_q <= 1'b0;
      rd_q  <= '0;
    end else begin
      oor_q <= oor_d;
      rd_q  <= rd_d;
    end
  end

  assign oor   = oor_q;
  assign rdata = rd_q;

  // R8: an out-of-range flag carries zero data
  p_oor_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    oor |-> (rdata == '0));
  // R8: the flag follows a real access
  p_oor_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    oor |-> $past(req));
endmodule

// File: rtl/syscfg_lock.sv
module syscfg_lock
  import syscfg_pkg::*;
#(
  parameter int               DW      = 16,
  parameter int               RAM_AW  = 11,
  parameter logic [REG_W-1:0] KEY_VAL = 16'h0096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_addr,
  input  logic              reg_we,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              fl_req,
  input  logic [DW-1:0]     fl_arr_data,
  output logic              fl_ready,
  output logic [DW-1:0]     fl_rdata,
  input  logic              ram_req,
  input  logic [RAM_AW-1:0] ram_addr,
  input  logic [DW-1:0]     ram_arr_data,
  output logic              ram_oor,
  output logic [DW-1:0]     ram_rdata
);
  logic [1:0]          rst_sync_q;
  logic                rst_int_n;
  logic [RAMSZ_W-1:0]  ramsz;
  logic [FLWAIT_W-1:0] flwait;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  syscfg_regbank #(.KEY_VAL(KEY_VAL)) u_bank (
    .clk(clk), .rst_n(rst_int_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .ramsz_o(ramsz), .flwait_o(flwait)
  );

  syscfg_flash_wait #(.WAIT_W(FLWAIT_W), .DW(DW)) u_flash (
    .clk(clk), .rst_n(rst_int_n), .wait_cfg(flwait), .req(fl_req),
    .arr_data(fl_arr_data), .ready(fl_ready), .rdata(fl_rdata)
  );

  syscfg_ram_window #(.AW(RAM_AW), .DW(DW), .CODE_W(RAMSZ_W), .BASE_SHIFT(9)) u_ram (
    .clk(clk), .rst_n(rst_int_n), .size_code(ramsz), .req(ram_req),
    .addr(ram_addr), .arr_data(ram_arr_data), .oor(ram_oor), .rdata(ram_rdata)
  );
endmodule

// File: tb/syscfg_lock_test.sv
module syscfg_lock_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        fl_req = 1'b0;
  logic [15:0] fl_arr_data = '0;
  logic        fl_ready;
  logic [15:0] fl_rdata;
  logic        ram_req = 1'b0;
  logic [10:0] ram_addr = '0;
  logic [15:0] ram_arr_data = '0;
  logic        ram_oor;
  logic [15:0] ram_rdata;

  int checks = 0;
  int fails = 0;
  logic [15:0] m_key;
  logic [2:0]  m_ram;
  logic [1:0]  m_fw;
  bit          done = 0;

  always #4 clk = ~clk;

  syscfg_lock uut (.*);

  function automatic bit unlocked_f(input logic [15:0] k);
    return k == 16'h0096;
  endfunction
  function automatic int win_f(input logic [2:0] c);
    return 512 << c;
  endfunction
  function automatic logic [15:0] rd_exp_f(input logic [1:0] a);
    case (a)
      2'd0: return m_key;
      2'd1: return {13'd0, m_ram};
      2'd2: return {14'd0, m_fw};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    case (a)
      2'd0: m_key = d;
      2'd1: if (unlocked_f(m_key) && d[2:0] <= 3'd2) m_ram = d[2:0];
      2'd2: if (unlocked_f(m_key)) m_fw = d[1:0];
      default: ;
    endcase
  endtask

  task automatic rd(input logic [1:0] a, input string req);
    reg_addr = a;
    #1;
    chk(reg_rdata == rd_exp_f(a), req, reg_rdata, rd_exp_f(a));
  endtask

  task automatic ram_acc(input logic [10:0] a, input logic [15:0] d, input string req);
    bit over;
    @(negedge clk);
    ram_req = 1'b1; ram_addr = a; ram_arr_data = d;
    over = int'(a) >= win_f(m_ram);
    @(negedge clk);
    ram_req = 1'b0;
    chk(ram_oor == over, req, ram_oor, over);
    chk(ram_rdata == (over ? 16'h0 : d), req, ram_rdata, over ? 0 : d);
    @(negedge clk);
    chk(ram_oor == 1'b0, "R8 flag one cycle", ram_oor, 0);
  endtask

  // newfw >= 0 rewrites the wait field in cycle 1; extra re-requests in cycle 2 and in ready cycle
  task automatic fl_acc(input logic [15:0] d, input int newfw, input bit extra_req, input string req);
    int n;
    logic [1:0] nf;
    n = int'(m_fw) + 1;
    nf = 2'(newfw);
    @(negedge clk);
    fl_req = 1'b1; fl_arr_data = d;
    for (int i = 1; i <= n + 3; i++) begin
      @(negedge clk);
      fl_req = 1'b0;
      reg_we = 1'b0;
      if (i == 1 && newfw >= 0) begin
        reg_addr = 2'd2; reg_wdata = {14'd0, nf}; reg_we = 1'b1;
        if (unlocked_f(m_key)) m_fw = nf;
      end
      if (extra_req && (i == 2 || i == n)) fl_req = 1'b1;
      chk(fl_ready == (i == n), req, fl_ready, i == n);
      chk(fl_rdata == ((i == n) ? d : 16'h0), "R6 data gate", fl_rdata, (i == n) ? d : 0);
    end
    fl_req = 1'b0;
    reg_we = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1729));
    m_key = 16'h0; m_ram = 3'd2; m_fw = 2'd1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(2'd0, "R1 key reset");
    rd(2'd1, "R1 ram size reset");
    rd(2'd2, "R1 wait reset");
    chk(fl_ready == 1'b0 && ram_oor == 1'b0, "R1 outputs idle", {fl_ready, ram_oor}, 0);
    // R3 locked writes dropped
    wr(2'd1, 16'h0000); rd(2'd1, "R3 locked ram size");
    wr(2'd2, 16'h0003); rd(2'd2, "R3 locked wait");
    // R2 unlock
    wr(2'd0, 16'h0096); rd(2'd0, "R2 key readback");
    wr(2'd2, 16'h0003); rd(2'd2, "R2 unlocked wait write");
    // R4 reserved codes
    wr(2'd1, 16'h0001); rd(2'd1, "R4 legal code");
    wr(2'd1, 16'h0005); rd(2'd1, "R4 reserved code ignored");
    wr(2'd1, 16'h0003); rd(2'd1, "R4 code 3 ignored");
    // R5 bit 8 and upper bits
    wr(2'd2, 16'hFF02); rd(2'd2, "R5 upper bits zero");
    wr(2'd1, 16'h0100); rd(2'd1, "R5 bit8 zero");
    // R11 unmapped word
    wr(2'd3, 16'hFFFF); rd(2'd3, "R11 unmapped read");
    rd(2'd0, "R11 key untouched"); rd(2'd1, "R11 size untouched"); rd(2'd2, "R11 wait untouched");
    // R2 relock with near-miss key
    wr(2'd0, 16'h0097); wr(2'd2, 16'h0001); rd(2'd2, "R2 relock");
    wr(2'd0, 16'h0096);
    // R6 latency for each wait code
    for (int w = 0; w < 4; w++) begin
      wr(2'd2, 16'(w));
      fl_acc(16'(16'hA000 + w), -1, 1'b0, "R6 ready latency");
    end
    // R7 change during access
    wr(2'd2, 16'h0003);
    fl_acc(16'hBEEF, 0, 1'b0, "R7 mid-access change");
    fl_acc(16'hBEE0, -1, 1'b0, "R7 new value next access");
    // R10 requests while busy ignored
    wr(2'd2, 16'h0002);
    fl_acc(16'hCAFE, -1, 1'b1, "R10 busy request ignored");
    // R8/R9 window edges
    for (int c = 0; c < 3; c++) begin
      wr(2'd1, 16'(c));
      ram_acc(11'(win_f(3'(c)) - 1), 16'h1234, "R9 last in-window byte");
      if (c < 2) ram_acc(11'(win_f(3'(c))), 16'h5678, "R8 first byte past window");
    end
    ram_acc(11'd0, 16'h4321, "R9 offset zero");
    // random mix
    for (int it = 0; it < 300; it++) begin
      int op;
      logic [15:0] d;
      op = int'($urandom_range(0, 4));
      d = 16'($urandom);
      case (op)
        0: wr(2'd0, ($urandom_range(0, 1) == 0) ? 16'h0096 : d);
        1: begin wr(2'($urandom_range(1, 3)), d); rd(2'($urandom_range(0, 3)), "R3 random register"); end
        2: rd(2'($urandom_range(0, 3)), "R5 random read");
        3: ram_acc(11'($urandom), d, "R8 random ram");
        default: fl_acc(d, -1, 1'b0, "R6 random flash");
      endcase
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule